// File: doc/BRIEF.md
# Interrupt Mask and Force Register Bank

This block holds the per-source gating state for a bank of 64 interrupt inputs. The sources are split into a low half (sources 0 to 31) and a high half (sources 32 to 63). Each half has three 32-bit registers on a simple register bus: a read-only pending view, a mask and a software force.

The block merges each raw source with its mask bit and its force bit. The result is a registered per-source request vector, plus a registered flag that is set when any request is active. Both go to a downstream prioritizer. A set force bit asserts its request whatever the mask holds. Because the masks come out of reset fully set, no raw source reaches the outputs until software opens it.

Register access is word-addressed. Writes are synchronous, with a write enable. Reads are combinational from the address.

Top module: `irq_mask_force_bank`

## Requirements
- R1: On reset every mask bit is 1, every force bit is 0, and `reqOut` and `anyReq` are 0.
- R2: A mask bit of 1 blocks its raw source and a mask bit of 0 passes it. After each clock edge, `reqOut[i]` equals (srcIn[i] AND NOT mask[i]) OR force[i], using the values present before that edge.
- R3: Reading a pending address returns the live `srcIn` bits of that half whatever the mask holds.
- R4: Writing 1 to a force bit asserts that source's request even while its mask bit is 1. Writing 0 withdraws the forced request.
- R5: A write to a mask or force address updates that register at the clock edge where `regWrEn` is high. A later read of the same address returns the written word.
- R6: The word addresses are: 0 pending high, 1 pending low, 2 mask high, 3 mask low, 4 force high, 5 force low. Writes to addresses 0, 1, 6 and 7 change no state. Addresses 6 and 7 read as 0.
- R7: Bit j of a low register belongs to source j. Bit j of a high register belongs to source 32+j.
- R8: `anyReq` is 1 exactly when at least one bit of `reqOut` is 1, in the same cycle.
- R9: A change on `srcIn` or on a register shows up on `reqOut` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Word address of the register access |
| regWrEn | input | 1 | Write strobe, sampled at the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| srcIn | input | 64 | Raw interrupt source levels |
| reqOut | output | 64 | Registered per-source request vector |
| anyReq | output | 1 | Registered OR of all requests |

## Verification
The assertions assume that `srcIn`, `regAddr`, `regWrEn` and `regWrData` are stable around each rising edge. They also assume that reset is applied from time zero, so the properties after a force write and after reset refer to known register contents. The bench drives every input only on the falling edge and holds reset from the first instant. Its random phase draws addresses from the full 3-bit range, so the unused and read-only addresses are hit within the same rules.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Width of the half selector carried in the strobe struct (up to 16 halves).
  localparam int HALF_SEL_W = 4;

  typedef enum logic [1:0] {
    KIND_PEND  = 2'd0,
    KIND_MASK  = 2'd1,
    KIND_FORCE = 2'd2,
    KIND_NONE  = 2'd3
  } regKindE;

  typedef struct packed {
    logic                  wrStb;   // write to a writable register
    regKindE               kind;    // register kind addressed
    logic [HALF_SEL_W-1:0] halfSel; // which half (0 = sources 0..HALF_W-1)
  } ctrlStrobeT;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_HALF = 2,
  parameter int ADDR_W   = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobeT        strobe
);

  localparam int NUM_KIND = 3;

  // Address layout: kind * NUM_HALF + position; position 0 is the top half.
  always_comb begin
    strobe         = '0;
    strobe.kind    = KIND_NONE;
    for (int k = 0; k < NUM_KIND; k++) begin
      for (int p = 0; p < NUM_HALF; p++) begin
        if (int'(regAddr) == k * NUM_HALF + p) begin
          strobe.kind    = regKindE'(k[1:0]);
          strobe.halfSel = HALF_SEL_W'(NUM_HALF - 1 - p);
        end
      end
    end
    // Pending view is read-only; unused addresses never write.
    strobe.wrStb = regWrEn && ((strobe.kind == KIND_MASK) || (strobe.kind == KIND_FORCE));
  end

endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int HALF_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [HALF_W-1:0]  regWrData,
  output logic [HALF_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] reqOut,
  output logic               anyReq
);

  localparam int NUM_HALF = NUM_SRC / HALF_W;

  logic [NUM_SRC-1:0] maskFlat;
  logic [NUM_SRC-1:0] forceFlat;
  logic [NUM_SRC-1:0] nextReq;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic [HALF_W-1:0] maskQ;
    logic [HALF_W-1:0] forceQ;
    logic              hitHalf;

    assign hitHalf = strobe.wrStb && (strobe.halfSel == HALF_SEL_W'(h));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ  <= '1;
        forceQ <= '0;
      end else if (hitHalf) begin
        if (strobe.kind == KIND_MASK)  maskQ  <= regWrData;
        if (strobe.kind == KIND_FORCE) forceQ <= regWrData;
      end
    end

    assign maskFlat[h*HALF_W +: HALF_W]  = maskQ;
    assign forceFlat[h*HALF_W +: HALF_W] = forceQ;
  end

  assign nextReq = (srcIn & ~maskFlat) | forceFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOut <= '0;
      anyReq <= 1'b0;
    end else begin
      reqOut <= nextReq;
      anyReq <= |nextReq;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (strobe.halfSel == HALF_SEL_W'(h)) begin
        case (strobe.kind)
          KIND_PEND:  regRdData = srcIn[h*HALF_W +: HALF_W];
          KIND_MASK:  regRdData = maskFlat[h*HALF_W +: HALF_W];
          KIND_FORCE: regRdData = forceFlat[h*HALF_W +: HALF_W];
          default:    regRdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_mask_force_bank.sv
module irq_mask_force_bank
  import irq_bank_pkg::*;
#(
  parameter  int NUM_SRC  = 64,
  parameter  int HALF_W   = 32,
  localparam int NUM_HALF = NUM_SRC / HALF_W,
  localparam int ADDR_W   = $clog2(3 * NUM_HALF + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [HALF_W-1:0]  regWrData,
  output logic [HALF_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] reqOut,
  output logic               anyReq
);

  ctrlStrobeT strobe;

  irq_bank_ctrl #(
    .NUM_HALF(NUM_HALF),
    .ADDR_W  (ADDR_W)
  ) i_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  irq_bank_datapath #(
    .NUM_SRC(NUM_SRC),
    .HALF_W (HALF_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .srcIn    (srcIn),
    .reqOut   (reqOut),
    .anyReq   (anyReq)
  );

endmodule

// File: rtl/irq_mask_force_chk.sv
module irq_mask_force_chk #(
  parameter int NUM_SRC = 64,
  parameter int HALF_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [HALF_W-1:0]  regWrData,
  input logic [HALF_W-1:0]  regRdData,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SRC-1:0] reqOut,
  input logic               anyReq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> (reqOut == '0) && !anyReq);

  // R8
  any_matches_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyReq == (reqOut != '0));

  // R3
  pend_low_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(1)) |-> (regRdData == srcIn[HALF_W-1:0]));

  // R7
  pend_high_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (regRdData == srcIn[NUM_SRC-1 -: HALF_W]));

  // R4
  force_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(5) && regWrData[0]) |=> ##1 reqOut[0]);

  // R6
  unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) >= 6) |-> (regRdData == '0));

endmodule

bind irq_mask_force_bank irq_mask_force_chk #(
  .NUM_SRC(NUM_SRC),
  .HALF_W (HALF_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .srcIn    (srcIn),
  .reqOut   (reqOut),
  .anyReq   (anyReq)
);

// File: tb/test_irq_mask_force_bank.sv
`timescale 1ns/1ps
module test_irq_mask_force_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] srcIn = '0;
  logic [63:0] reqOut;
  logic        anyReq;

  int testCnt = 0;
  int failCnt = 0;
  string phaseTag = "R1";

  // Behavioural reference state
  bit [63:0] mMask, mForce, mReq;
  bit        mAny;

  always #2.5 clk = ~clk;

  irq_mask_force_bank i_irq_mask_force_bank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .srcIn(srcIn),
    .reqOut(reqOut), .anyReq(anyReq)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = '1; mForce = '0; mReq = '0; mAny = 1'b0;
    end else begin
      bit [63:0] r;
      r = (srcIn & ~mMask) | mForce;
      mReq = r;
      mAny = (r != 0);
      if (regWrEn) begin
        case (regAddr)
          3'd2: mMask[63:32]  = regWrData;
          3'd3: mMask[31:0]   = regWrData;
          3'd4: mForce[63:32] = regWrData;
          3'd5: mForce[31:0]  = regWrData;
          default: ;
        endcase
      end
    end
  end

  function automatic bit [31:0] modelRead(input bit [2:0] a);
    case (a)
      3'd0: return srcIn[63:32];
      3'd1: return srcIn[31:0];
      3'd2: return mMask[63:32];
      3'd3: return mMask[31:0];
      3'd4: return mForce[63:32];
      3'd5: return mForce[31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check64({phaseTag, " R2/R9 reqOut"}, reqOut, mReq);
    check64({phaseTag, " R8 anyReq"}, {63'd0, anyReq}, {63'd0, mAny});
    check64({phaseTag, " R5/R6 read"}, {32'd0, regRdData}, {32'd0, modelRead(regAddr)});
  endtask

  // One cycle: compare at falling edge, then drive new inputs.
  task automatic step(input bit [2:0] a, input bit we, input bit [31:0] d, input bit [63:0] s);
    @(negedge clk);
    compareAll();
    regAddr = a; regWrEn = we; regWrData = d; srcIn = s;
  endtask

  task automatic readAt(input string tag, input bit [2:0] a, input bit [31:0] exp, input bit [63:0] s);
    step(a, 1'b0, 32'd0, s);
    #0.5;
    check64(tag, {32'd0, regRdData}, {32'd0, exp});
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    bit [63:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    check64("R1 reqOut after reset", reqOut, 64'd0);
    check64("R1 anyReq after reset", {63'd0, anyReq}, 64'd0);
    rstN = 1'b1;
    readAt("R1 mask low reset", 3'd3, 32'hFFFF_FFFF, 64'd0);
    readAt("R1 mask high reset", 3'd2, 32'hFFFF_FFFF, 64'd0);
    readAt("R1 force low reset", 3'd5, 32'd0, 64'd0);

    // R2/R3: sources active, all masked
    phaseTag = "R2";
    s = 64'hDEAD_BEEF_0123_4567;
    readAt("R3 pending low while masked", 3'd1, s[31:0], s);
    readAt("R3 pending high while masked", 3'd0, s[63:32], s);
    @(negedge clk); #0.5;
    check64("R2 masked sources give no request", reqOut, 64'd0);

    // R7: unmask low half only
    phaseTag = "R7";
    step(3'd3, 1'b1, 32'h0, s);
    repeat (3) step(3'd3, 1'b0, 32'd0, s);
    #0.5;
    check64("R7 low half unmasked", reqOut, {32'd0, s[31:0]});
    readAt("R5 mask low readback", 3'd3, 32'd0, s);

    // R9: one-edge latency on a source change
    phaseTag = "R9";
    step(3'd1, 1'b0, 32'd0, 64'd0);
    step(3'd1, 1'b0, 32'd0, 64'h1);
    @(negedge clk); #0.5;
    check64("R9 source change after one edge", reqOut, 64'h1);

    // R4: force a masked high source, then withdraw
    phaseTag = "R4";
    step(3'd4, 1'b1, 32'h0000_0020, 64'd0);
    repeat (2) step(3'd0, 1'b0, 32'd0, 64'd0);
    #0.5;
    check64("R4 forced masked source 37", reqOut, 64'h1 << 37);
    step(3'd4, 1'b1, 32'h0, 64'd0);
    repeat (2) step(3'd0, 1'b0, 32'd0, 64'd0);
    #0.5;
    check64("R4 force withdrawn", reqOut, 64'd0);

    // R6: writes to pending and unused addresses are ignored
    phaseTag = "R6";
    step(3'd1, 1'b1, 32'hFFFF_FFFF, 64'd0);
    step(3'd6, 1'b1, 32'hFFFF_FFFF, 64'd0);
    step(3'd7, 1'b1, 32'hFFFF_FFFF, 64'd0);
    readAt("R6 pending still raw", 3'd1, 32'd0, 64'd0);
    readAt("R6 unused address reads zero", 3'd6, 32'd0, 64'd0);
    readAt("R6 force low unchanged", 3'd5, 32'd0, 64'd0);
    readAt("R6 mask high unchanged", 3'd2, 32'hFFFF_FFFF, 64'd0);

    // Random traffic against the reference model
    phaseTag = "RND";
    for (int i = 0; i < 400; i++) begin
      step(3'($urandom), 1'($urandom), $urandom, {$urandom, $urandom});
    end
    step(3'd0, 1'b0, 32'd0, 64'd0);
    @(negedge clk);
    compareAll();

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule